// File: doc/BRIEF.md
# Pipelined Floating-Point Square Root

This block takes the square root of a binary floating-point number in the usual sign/exponent/fraction layout. The three field widths are set by parameters. The default is the 32-bit single format, with 8 exponent bits and 23 fraction bits. Wider formats, such as the 64-bit one with 11 and 52 bits, come from the same parameters. The operand is packed with the sign in the MSB, the biased exponent below it and the fraction in the LSBs. The exponent bias is 2^(WIDTH_EXP-1)-1. The result uses the same packing.

The unit is fully pipelined. It accepts a new operand on every enabled clock and returns the result a fixed WIDTH_MAN+5 enabled cycles later, together with three status flags: infinite input, zero result and invalid result. Rounding is always round-to-nearest-even. A denormal operand is treated as a zero of the same sign.

Flow control is the clock enable alone. Holding `clk_en` low is the back-pressure mechanism: the whole pipe freezes, the operand pins are not sampled and every output holds its value. There is no per-operand valid signal, so the surrounding logic tracks which result cycles carry data by counting enabled cycles. An active-high asynchronous clear empties every stage.

Top module: `fp_sqrt_pipe`

## Requirements
- R1: An operand presented before enabled clock edge n appears on the outputs after enabled edge n+WIDTH_MAN+4, so it is visible WIDTH_MAN+5 enabled cycles later (28 for the default format). The output does not change one cycle earlier. A new operand is accepted on every enabled cycle.
- R2: A positive normal operand gives a positive result with biased exponent floor((E+bias)/2). The fraction is the square root rounded to nearest-even. All three flags are low.
- R3: When the unbiased exponent E-bias is odd, the factor of two is folded into the fraction. For example, 2.0 (0x40000000) gives 0x3FB504F3 and 8.0 gives 0x40350 4F3 with no space, that is 0x403504F3.
- R4: An operand with an exponent field of zero (zero or denormal) gives zero with the operand's sign: 0x00000000 for positive and 0x80000000 for negative. `zero_flag` is high and the other flags are low.
- R5: Positive infinity (exponent all ones, fraction zero, sign 0) gives positive infinity, with `ovf_flag` high and the other flags low.
- R6: Any NaN (exponent all ones, fraction non-zero), negative infinity or negative normal operand gives a result of all ones, with `nan_flag` high and the other flags low.
- R7: While `clk_en` is low, every output holds its value, the operand is ignored and operands already in flight are neither lost nor duplicated. Their results arrive late by the number of stalled cycles.
- R8: Raising `aclr` drives the result and flags to zero at once, without a clock edge, and discards every operand in flight.
- R9: With HAS_FLAGS set to 0, the three flag outputs stay low and the result is unchanged.
- R10: At most one flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| aclr | input | 1 | Asynchronous clear, active high |
| clk_en | input | 1 | Clock enable; low freezes the pipeline |
| operand | input | 1+WIDTH_EXP+WIDTH_MAN | Packed floating-point operand |
| root_out | output | 1+WIDTH_EXP+WIDTH_MAN | Packed floating-point result |
| ovf_flag | output | 1 | Operand was positive infinity |
| zero_flag | output | 1 | Result is a signed zero |
| nan_flag | output | 1 | Result is invalid (all ones) |

## Verification
A corrupted partial remainder or root bit in one recurrence stage reaches the ports as a wrong fraction in exactly the one result that passed through that stage, WIDTH_MAN+5 enabled cycles after that operand entered. Random back-to-back operands are therefore compared one for one against a bit-exact integer model, so such an error cannot be hidden by a neighbouring operand. A class tag that falls out of step with its data shows up as a flag or special-value override landing on the wrong output cycle. A stage that keeps advancing while `clk_en` is low shows up as a result arriving early or twice around a stall. A stage that survives `aclr` shows up as a non-zero output within WIDTH_MAN+5 cycles after the clear is released.

// File: rtl/fp_sqrt_pkg.sv
package fp_sqrt_pkg;
  // class of an operand, decided on entry and carried beside the data
  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } sq_class_t;
endpackage

// File: rtl/fp_sqrt_unpack.sv
module fp_sqrt_unpack
  import fp_sqrt_pkg::*;
#(
  parameter int WE = 8,
  parameter int WM = 23
) (
  input  logic                   clk,
  input  logic                   aclr,
  input  logic                   en,
  input  logic [WE+WM:0]         operand,
  output logic [2*(WM+2)-1:0]    rad_o,
  output logic [WE-1:0]          exp_o,
  output logic                   sign_o,
  output sq_class_t              cls_o
);
  localparam int RADW = 2 * (WM + 2);
  localparam logic [WE:0] BIAS_X = {2'b00, {(WE-1){1'b1}}};

  logic          sgn;
  logic [WE-1:0] ex;
  logic [WM-1:0] mn;
  logic [WE:0]   ex_sum;
  logic [RADW-1:0] mant_x;
  logic [RADW-1:0] rad_n;
  sq_class_t     cls_n;

  assign sgn = operand[WE+WM];
  assign ex  = operand[WE+WM-1:WM];
  assign mn  = operand[WM-1:0];

  always_comb begin
    if ((&ex) && (|mn))   cls_n = CLS_NAN;
    else if (~|ex)        cls_n = CLS_ZERO;
    else if (sgn)         cls_n = CLS_NAN;
    else if (&ex)         cls_n = CLS_INF;
    else                  cls_n = CLS_NORM;
  end

  // (E + bias) / 2 is the result exponent; its LSB says the true exponent is odd
  assign ex_sum = {1'b0, ex} + BIAS_X;
  assign mant_x = {{(RADW-WM-1){1'b0}}, 1'b1, mn};

  always_comb begin
    if (cls_n != CLS_NORM) rad_n = '0;
    else if (ex_sum[0])    rad_n = mant_x << (WM + 3);
    else                   rad_n = mant_x << (WM + 2);
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      rad_o  <= '0;
      exp_o  <= '0;
      sign_o <= 1'b0;
      cls_o  <= CLS_NORM;
    end else if (en) begin
      rad_o  <= rad_n;
      exp_o  <= ex_sum[WE:1];
      sign_o <= sgn;
      cls_o  <= cls_n;
    end
  end
endmodule

// File: rtl/fp_sqrt_step.sv
module fp_sqrt_step
  import fp_sqrt_pkg::*;
#(
  parameter int WE = 8,
  parameter int N  = 25
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              en,
  input  logic [2*N-1:0]    rad_i,
  input  logic [N+1:0]      rem_i,
  input  logic [N-1:0]      root_i,
  input  logic [WE-1:0]     exp_i,
  input  logic              sign_i,
  input  sq_class_t         cls_i,
  output logic [2*N-1:0]    rad_o,
  output logic [N+1:0]      rem_o,
  output logic [N-1:0]      root_o,
  output logic [WE-1:0]     exp_o,
  output logic              sign_o,
  output sq_class_t         cls_o
);
  // one restoring digit of the integer square root per stage
  logic [N+3:0] rem_sh;
  logic [N+3:0] trial;
  logic [N+3:0] rem_n;
  logic         fits;

  assign rem_sh = {rem_i, rad_i[2*N-1:2*N-2]};
  assign trial  = {2'b00, root_i, 2'b01};
  assign fits   = (rem_sh >= trial);
  assign rem_n  = fits ? (rem_sh - trial) : rem_sh;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      rad_o  <= '0;
      rem_o  <= '0;
      root_o <= '0;
      exp_o  <= '0;
      sign_o <= 1'b0;
      cls_o  <= CLS_NORM;
    end else if (en) begin
      rad_o  <= rad_i << 2;
      rem_o  <= rem_n[N+1:0];
      root_o <= {root_i[N-2:0], fits};
      exp_o  <= exp_i;
      sign_o <= sign_i;
      cls_o  <= cls_i;
    end
  end
endmodule

// File: rtl/fp_sqrt_pack.sv
module fp_sqrt_pack
  import fp_sqrt_pkg::*;
#(
  parameter int WE = 8,
  parameter int WM = 23
) (
  input  logic            clk,
  input  logic            aclr,
  input  logic            en,
  input  logic [WM+1:0]   root_i,
  input  logic [WM+3:0]   rem_i,
  input  logic [WE-1:0]   exp_i,
  input  logic            sign_i,
  input  sq_class_t       cls_i,
  output logic [WE+WM:0]  res_o,
  output logic            ovf_o,
  output logic            zero_o,
  output logic            nan_o
);
  logic            round_up;
  logic [WE+WM-1:0] body;
  logic [WE+WM:0]  res_n;

  // root_i: hidden one, WM fraction bits, one guard bit; rem_i non-zero is sticky
  assign round_up = root_i[0] & ((|rem_i) | root_i[1]);
  assign body     = {exp_i, root_i[WM:1]} + {{(WE+WM-1){1'b0}}, round_up};

  always_comb begin
    unique case (cls_i)
      CLS_ZERO: res_n = {sign_i, {(WE+WM){1'b0}}};
      CLS_INF:  res_n = {1'b0, {WE{1'b1}}, {WM{1'b0}}};
      CLS_NAN:  res_n = '1;
      default:  res_n = {1'b0, body};
    endcase
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      res_o  <= '0;
      ovf_o  <= 1'b0;
      zero_o <= 1'b0;
      nan_o  <= 1'b0;
    end else if (en) begin
      res_o  <= res_n;
      ovf_o  <= (cls_i == CLS_INF);
      zero_o <= (cls_i == CLS_ZERO);
      nan_o  <= (cls_i == CLS_NAN);
    end
  end
endmodule

// File: rtl/fp_sqrt_pipe.sv
module fp_sqrt_pipe
  import fp_sqrt_pkg::*;
#(
  parameter int WIDTH_EXP = 8,
  parameter int WIDTH_MAN = 23,
  parameter bit HAS_FLAGS = 1'b1
) (
  input  logic                            clk,
  input  logic                            aclr,
  input  logic                            clk_en,
  input  logic [WIDTH_EXP+WIDTH_MAN:0]    operand,
  output logic [WIDTH_EXP+WIDTH_MAN:0]    root_out,
  output logic                            ovf_flag,
  output logic                            zero_flag,
  output logic                            nan_flag
);
  localparam int W    = 1 + WIDTH_EXP + WIDTH_MAN;
  localparam int N    = WIDTH_MAN + 2;   // root bits: hidden + fraction + guard
  localparam int RADW = 2 * N;

  logic [RADW-1:0]      rad_s  [0:N];
  logic [N+1:0]         rem_s  [0:N];
  logic [N-1:0]         root_s [0:N];
  logic [WIDTH_EXP-1:0] exp_s  [0:N];
  logic                 sign_s [0:N];
  sq_class_t            cls_s  [0:N];

  logic [W-1:0] res_p;
  logic         ovf_p, zero_p, nan_p;
  logic [W-1:0] res_q;
  logic         ovf_q, zero_q, nan_q;

  fp_sqrt_unpack #(.WE(WIDTH_EXP), .WM(WIDTH_MAN)) u_unpack (
    .clk    (clk),
    .aclr   (aclr),
    .en     (clk_en),
    .operand(operand),
    .rad_o  (rad_s[0]),
    .exp_o  (exp_s[0]),
    .sign_o (sign_s[0]),
    .cls_o  (cls_s[0])
  );

  assign rem_s[0]  = '0;
  assign root_s[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_step
    fp_sqrt_step #(.WE(WIDTH_EXP), .N(N)) u_step (
      .clk   (clk),
      .aclr  (aclr),
      .en    (clk_en),
      .rad_i (rad_s[k]),
      .rem_i (rem_s[k]),
      .root_i(root_s[k]),
      .exp_i (exp_s[k]),
      .sign_i(sign_s[k]),
      .cls_i (cls_s[k]),
      .rad_o (rad_s[k+1]),
      .rem_o (rem_s[k+1]),
      .root_o(root_s[k+1]),
      .exp_o (exp_s[k+1]),
      .sign_o(sign_s[k+1]),
      .cls_o (cls_s[k+1])
    );
  end

  fp_sqrt_pack #(.WE(WIDTH_EXP), .WM(WIDTH_MAN)) u_pack (
    .clk   (clk),
    .aclr  (aclr),
    .en    (clk_en),
    .root_i(root_s[N]),
    .rem_i (rem_s[N]),
    .exp_i (exp_s[N]),
    .sign_i(sign_s[N]),
    .cls_i (cls_s[N]),
    .res_o (res_p),
    .ovf_o (ovf_p),
    .zero_o(zero_p),
    .nan_o (nan_p)
  );

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      zero_q <= 1'b0;
      nan_q  <= 1'b0;
    end else if (clk_en) begin
      res_q  <= res_p;
      ovf_q  <= ovf_p;
      zero_q <= zero_p;
      nan_q  <= nan_p;
    end
  end

  assign root_out = res_q;

  if (HAS_FLAGS) begin : g_flags
    assign ovf_flag  = ovf_q;
    assign zero_flag = zero_q;
    assign nan_flag  = nan_q;
  end else begin : g_no_flags
    assign ovf_flag  = 1'b0;
    assign zero_flag = 1'b0;
    assign nan_flag  = 1'b0;
  end
endmodule

// File: rtl/fp_sqrt_checks.sv
module fp_sqrt_checks #(
  parameter int W  = 32,
  parameter int WE = 8
) (
  input logic         clk,
  input logic         aclr,
  input logic         clk_en,
  input logic [W-1:0] root_out,
  input logic         ovf_flag,
  input logic         zero_flag,
  input logic         nan_flag
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (aclr)
    !clk_en |=> ($stable(root_out) && $stable({ovf_flag, zero_flag, nan_flag})));

  assert_onehot_R10: assert property (@(posedge clk) disable iff (aclr)
    $onehot0({ovf_flag, zero_flag, nan_flag}));

  assert_nan_ones_R6: assert property (@(posedge clk) disable iff (aclr)
    nan_flag |-> (&root_out));

  assert_inf_value_R5: assert property (@(posedge clk) disable iff (aclr)
    ovf_flag |-> (root_out == {1'b0, {WE{1'b1}}, {(W-1-WE){1'b0}}}));

  assert_zero_value_R4: assert property (@(posedge clk) disable iff (aclr)
    zero_flag |-> (root_out[W-2:0] == '0));
endmodule

bind fp_sqrt_pipe fp_sqrt_checks #(
  .W (1 + WIDTH_EXP + WIDTH_MAN),
  .WE(WIDTH_EXP)
) u_checks (
  .clk      (clk),
  .aclr     (aclr),
  .clk_en   (clk_en),
  .root_out (root_out),
  .ovf_flag (ovf_flag),
  .zero_flag(zero_flag),
  .nan_flag (nan_flag)
);

// File: tb/test_fp_sqrt_pipe.sv
module test_fp_sqrt_pipe;
  localparam int LAT = 28;

  logic        clk = 1'b0;
  logic        aclr = 1'b1;
  logic        clk_en = 1'b1;
  logic [31:0] operand = 32'h0;
  logic [31:0] root_out, root_nf;
  logic        ovf_flag, zero_flag, nan_flag;
  logic        ovf_nf, zero_nf, nan_nf;

  int total = 0;
  int bad = 0;
  logic [31:0] ops [0:63];

  always #10 clk = ~clk;   // 50 MHz

  fp_sqrt_pipe i_fp_sqrt_pipe (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .operand(operand),
    .root_out(root_out), .ovf_flag(ovf_flag), .zero_flag(zero_flag), .nan_flag(nan_flag)
  );

  fp_sqrt_pipe #(.HAS_FLAGS(1'b0)) i_noflag (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .operand(operand),
    .root_out(root_nf), .ovf_flag(ovf_nf), .zero_flag(zero_nf), .nan_flag(nan_nf)
  );

  // independent model: {result, ovf, zero, nan}
  function automatic logic [34:0] ref_sqrt(input logic [31:0] a);
    logic        s;
    int          ex, e, odd, er;
    longint      mant, rr, sv, q;
    logic        up;
    s  = a[31];
    ex = int'(a[30:23]);
    if (ex == 255 && a[22:0] != 0) return {32'hFFFF_FFFF, 3'b001};
    if (ex == 0)                   return {s, 31'h0, 3'b010};
    if (s)                         return {32'hFFFF_FFFF, 3'b001};
    if (ex == 255)                 return {32'h7F80_0000, 3'b100};
    mant = (64'sd1 << 23) | longint'(a[22:0]);
    e    = ex - 127;
    odd  = e & 1;
    rr   = (odd != 0) ? (mant << 1) : mant;
    sv   = rr << 23;
    q    = longint'($floor($sqrt(real'(sv))));
    while (q * q > sv) q = q - 1;
    while ((q + 1) * (q + 1) <= sv) q = q + 1;
    up = (4 * sv > (2 * q + 1) * (2 * q + 1));
    q  = q + longint'(up);
    er = (e - odd) / 2 + 127;
    if (q >= (64'sd1 << 24)) begin q = q >> 1; er = er + 1; end
    return {1'b0, er[7:0], q[22:0], 3'b000};
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // stream ops[0..k-1] back to back; check each result LAT cycles later
  task automatic run_seq(input string tag, input int k, input bit with_nf);
    logic [34:0] e;
    for (int c = 0; c < k + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        e = ref_sqrt(ops[c-LAT]);
        check(tag, {root_out, ovf_flag, zero_flag, nan_flag}, e);
        total++;
        if (!$onehot0({ovf_flag, zero_flag, nan_flag})) begin
          bad++;
          $display("FAIL R10: flags=%b expected at most one set", {ovf_flag, zero_flag, nan_flag});
        end
        if (with_nf) check("R9", {root_nf, ovf_nf, zero_nf, nan_nf}, {e[34:3], 3'b000});
      end
      if (c < k) operand = ops[c];
    end
  endtask

  task automatic settle(input logic [31:0] a);
    operand = a;
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 reset", {root_out, ovf_flag, zero_flag, nan_flag}, 35'h0);
    aclr = 1'b0;
  endtask

  task automatic t_exact;
    ops[0] = 32'h3F80_0000; ops[1] = 32'h4080_0000; ops[2] = 32'h4110_0000;
    ops[3] = 32'h3E80_0000; ops[4] = 32'h4000_0000; ops[5] = 32'h4040_0000;
    ops[6] = 32'h0080_0000; ops[7] = 32'h7F7F_FFFF; ops[8] = 32'h4100_0000;
    ops[9] = 32'h3F00_0000;
    run_seq("R2/R3 exact", 10, 1'b1);
    // fixed values that do not depend on the model
    settle(32'h4000_0000);
    check("R3 sqrt2", {root_out, ovf_flag, zero_flag, nan_flag}, {32'h3FB5_04F3, 3'b000});
    settle(32'h4100_0000);
    check("R3 sqrt8", {root_out, ovf_flag, zero_flag, nan_flag}, {32'h4035_04F3, 3'b000});
    settle(32'h0080_0000);
    check("R2 min normal", {root_out, ovf_flag, zero_flag, nan_flag}, {32'h2000_0000, 3'b000});
    settle(32'h7F7F_FFFF);
    check("R2 max normal", {root_out, ovf_flag, zero_flag, nan_flag}, {32'h5F7F_FFFF, 3'b000});
  endtask

  task automatic t_random;
    for (int i = 0; i < 48; i++) begin
      ops[i] = {1'b0, 8'(1 + $urandom_range(0, 253)), 23'($urandom)};
    end
    run_seq("R1/R2 random stream", 48, 1'b0);
  endtask

  task automatic t_zero;
    ops[0] = 32'h0000_0000; ops[1] = 32'h8000_0000;
    ops[2] = 32'h0000_0001; ops[3] = 32'h807F_FFFF;
    ops[4] = 32'h0040_0000;
    run_seq("R4 zero/denormal", 5, 1'b1);
  endtask

  task automatic t_inf;
    ops[0] = 32'h7F80_0000; ops[1] = 32'h3F80_0000; ops[2] = 32'h7F80_0000;
    run_seq("R5 infinity", 3, 1'b1);
  endtask

  task automatic t_nan;
    ops[0] = 32'hFF80_0000; ops[1] = 32'h7FC0_0000; ops[2] = 32'hFFC0_0001;
    ops[3] = 32'hBF80_0000; ops[4] = 32'h8080_0000; ops[5] = 32'h7F80_0001;
    run_seq("R6 nan/negative", 6, 1'b1);
  endtask

  task automatic t_latency;
    logic [34:0] fa, fb;
    fa = ref_sqrt(32'h4080_0000);
    fb = ref_sqrt(32'h4110_0000);
    settle(32'h4080_0000);
    operand = 32'h4110_0000;           // enters at the next edge
    for (int c = 1; c <= LAT + 1; c++) begin
      @(negedge clk);
      operand = 32'h4080_0000;
      if (c == LAT - 1) check("R1 not early", {root_out, ovf_flag, zero_flag, nan_flag}, fa);
      if (c == LAT)     check("R1 on time", {root_out, ovf_flag, zero_flag, nan_flag}, fb);
      if (c == LAT + 1) check("R1 single result", {root_out, ovf_flag, zero_flag, nan_flag}, fa);
    end
  endtask

  task automatic t_stall;
    logic [34:0] fa, fb;
    int stall_n;
    stall_n = 6;
    fa = ref_sqrt(32'h3F80_0000);
    fb = ref_sqrt(32'h4040_0000);
    settle(32'h3F80_0000);
    operand = 32'h4040_0000;
    for (int c = 1; c <= LAT + stall_n + 12; c++) begin
      @(negedge clk);
      if (c >= 11 && c <= 10 + stall_n)
        check("R7 hold", {root_out, ovf_flag, zero_flag, nan_flag}, fa);
      if (c >= 10 && c < 10 + stall_n) begin
        clk_en  = 1'b0;
        operand = 32'h7F80_0000;     // must be ignored
      end else begin
        clk_en  = 1'b1;
        operand = 32'h3F80_0000;
      end
      if (c == LAT + stall_n - 1) check("R7 delayed", {root_out, ovf_flag, zero_flag, nan_flag}, fa);
      if (c == LAT + stall_n)     check("R7 arrives", {root_out, ovf_flag, zero_flag, nan_flag}, fb);
      if (c > LAT + stall_n)      check("R7 no capture", {root_out, ovf_flag, zero_flag, nan_flag}, fa);
    end
  endtask

  task automatic t_aclr;
    settle(32'h4080_0000);
    operand = 32'h4110_0000;
    repeat (5) @(negedge clk);
    #3 aclr = 1'b1;
    #1 check("R8 async clear", {root_out, ovf_flag, zero_flag, nan_flag}, 35'h0);
    @(negedge clk);
    aclr = 1'b0;
    operand = 32'h0000_0000;
    for (int c = 1; c <= LAT; c++) begin
      @(negedge clk);
      if (c < LAT) check("R8 flushed", {root_out, ovf_flag, zero_flag, nan_flag}, 35'h0);
      else         check("R8 first new", {root_out, ovf_flag, zero_flag, nan_flag}, {32'h0, 3'b010});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_exact();
    t_random();
    t_zero();
    t_inf();
    t_nan();
    t_latency();
    t_stall();
    t_aclr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule